// File: doc/BRIEF.md
# Firmware Configuration Register Front-End

This block is the memory-mapped register front end of a firmware-configuration device. Software picks one numbered configuration item by writing its key to a selector register. It then streams the item's bytes out of a data register. The block keeps the selected key and a byte cursor into that item. Each byte read moves the cursor forward. Item contents come from a small table that the block computes internally.

When the DMA option is built in, the window also holds a 64-bit descriptor-pointer register. This register is big-endian. Software loads it with the address of a transfer descriptor. A write to its low half hands the pointer to a separate transfer engine through a one-cycle start pulse. While the engine works, the register is locked and a busy flag is held high. When the engine reports completion, the register returns to zero. A feature item tells software whether the DMA path exists.

Top module: `fwc_regs`

## Requirements
- R1: After reset the selected key is 0 with the cursor at byte 0. `dma_busy` and `dma_start` are low, and `dma_desc_addr` is zero.
- R2: A read with `mmio_addr` below 0x8 is a data read of N = 1 << `mmio_size` bytes. `mmio_rvalid` is high in the cycle after the request, with `mmio_rdata`. Byte lane k (k < N) holds item byte cursor+k, lanes at or above N are zero, and the cursor advances by N. Item contents: key 0 is 4 bytes 0x43,0x46,0x57,0x31. Key k from 2 to NUM_ITEMS-1 has 2+3k bytes, and byte i is 16k+i.
- R3: A 2-byte write at offset 0x8 loads the selector from `mmio_wdata[15:0]` and resets the cursor to 0, even when the key does not change.
- R4: Data-read lanes past the end of the item return zero, and the cursor advances only over bytes that exist. Keys at or above NUM_ITEMS have length zero.
- R5: Key 1 is a 4-byte little-endian bitmap. Bit 0 is always set, and bit 1 is set when the DMA path is built.
- R6: The pointer register is big-endian: the byte at offset 0xC is the most significant. A 4-byte write at 0xC stores the high half and does not pulse `dma_start`.
- R7: A 4-byte write at 0x10 stores the low half and starts an operation. In the next cycle `dma_start` is high for exactly one cycle, and `dma_desc_addr` holds {high half, low half}.
- R8: An 8-byte write at 0xC loads both halves in one access and starts an operation.
- R9: `dma_busy` rises together with `dma_start` and stays high until `dma_done`. While it is high, writes to the pointer register are ignored and `dma_desc_addr` is stable.
- R10: In the cycle after `dma_done` is seen while busy, `dma_busy` is low and the pointer register reads zero.
- R11: Reads of the pointer register return its bytes in big-endian order. An 8-byte read at 0xC does this, and so does a 4-byte read at 0xC or at 0x10.
- R12: Writes to the data register have no effect. Accesses at other offsets (0xA, 0xB, 0x14 and up) have no effect and read zero. Write requests produce no `mmio_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_req | input | 1 | Access request, one cycle per access |
| mmio_we | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | ADDR_W | Byte offset in the window |
| mmio_size | input | 2 | Access size, 1 << value bytes |
| mmio_wdata | input | 64 | Write data, byte lane k at offset addr+k |
| mmio_rvalid | output | 1 | Read data valid, one cycle after a read |
| mmio_rdata | output | 64 | Read data |
| dma_done | input | 1 | Transfer engine finished the current operation |
| dma_start | output | 1 | One-cycle start pulse to the transfer engine |
| dma_busy | output | 1 | Operation in progress |
| dma_desc_addr | output | 64 | Descriptor pointer value |

## Verification
The bench builds the block with its defaults: DMA present, four items, an 8-bit cursor and a 5-bit offset. Items then have lengths 4, 4, 8 and 11 bytes. The 11-byte item lets several reads of mixed width run the cursor across the item end, mid-access. Key 7 covers an empty item, and the feature item shows bit 1 set. With the DMA path built in, both ways of loading the pointer, the lock while busy and the clear on completion can all be driven from the bus.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

   typedef enum logic [1:0] {
      SZ_1 = 2'd0,
      SZ_2 = 2'd1,
      SZ_4 = 2'd2,
      SZ_8 = 2'd3
   } acc_size_e;

   localparam int unsigned BUS_BYTES = 8;
   localparam int unsigned OFS_SEL   = 'h08;
   localparam int unsigned OFS_PHI   = 'h0C;
   localparam int unsigned OFS_PLO   = 'h10;
   localparam int unsigned KEY_SIG   = 0;
   localparam int unsigned KEY_FEAT  = 1;

   function automatic int unsigned item_len(int unsigned key, int unsigned n_items);
      if (key == KEY_SIG || key == KEY_FEAT) return 4;
      if (key < n_items) return 2 + 3 * key;
      return 0;
   endfunction

   function automatic logic [7:0] item_byte(int unsigned key, int unsigned idx, bit dma_en);
      if (key == KEY_SIG) begin
         case (idx)
            0: return 8'h43;
            1: return 8'h46;
            2: return 8'h57;
            default: return 8'h31;
         endcase
      end
      if (key == KEY_FEAT) return (idx == 0) ? {6'd0, dma_en, 1'b1} : 8'h00;
      return 8'((key << 4) + idx);
   endfunction

   function automatic logic [31:0] bswap32(logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

endpackage

// File: rtl/fwc_item_rom.sv
module fwc_item_rom #(
   parameter int unsigned SEL_W     = 16,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned NUM_ITEMS = 4,
   parameter bit          DMA_EN    = 1'b1
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [OFF_W-1:0] off_i,
   output logic [63:0]      bytes_o,
   output logic [OFF_W-1:0] len_o
);
   import fwc_pkg::*;

   assign len_o = OFF_W'(item_len(32'(sel_i), NUM_ITEMS));

   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
      logic [31:0] idx;
      assign idx = 32'(off_i) + 32'(k);
      assign bytes_o[8*k +: 8] = (idx < 32'(len_o)) ? item_byte(32'(sel_i), idx, DMA_EN) : 8'h00;
   end

endmodule

// File: rtl/fwc_sel_state.sv
module fwc_sel_state #(
   parameter int unsigned SEL_W = 16,
   parameter int unsigned OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr_i,
   input  logic [SEL_W-1:0] sel_d_i,
   input  logic             adv_en_i,
   input  logic [OFF_W-1:0] adv_i,
   output logic [SEL_W-1:0] sel_o,
   output logic [OFF_W-1:0] off_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_o <= '0;
         off_o <= '0;
      end else if (sel_wr_i) begin
         sel_o <= sel_d_i;
         off_o <= '0;
      end else if (adv_en_i) begin
         off_o <= off_o + adv_i;
      end
   end

endmodule

// File: rtl/fwc_dma_ptr.sv
module fwc_dma_ptr #(
   parameter bit DMA_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hi_i,
   input  logic        wr_lo_i,
   input  logic [31:0] hi_d_i,
   input  logic [31:0] lo_d_i,
   input  logic        done_i,
   output logic [63:0] val_o,
   output logic        busy_o,
   output logic        start_o
);

   if (DMA_EN) begin : g_ptr
      logic [31:0] hi_q, lo_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            busy_o  <= 1'b0;
            start_o <= 1'b0;
         end else begin
            start_o <= 1'b0;
            if (busy_o) begin
               if (done_i) begin
                  hi_q   <= '0;
                  lo_q   <= '0;
                  busy_o <= 1'b0;
               end
            end else begin
               if (wr_hi_i) hi_q <= hi_d_i;
               if (wr_lo_i) begin
                  lo_q    <= lo_d_i;
                  busy_o  <= 1'b1;
                  start_o <= 1'b1;
               end
            end
         end
      end
      assign val_o = {hi_q, lo_q};
   end else begin : g_noptr
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_hi_i, wr_lo_i, hi_d_i, lo_d_i, done_i};
      assign val_o   = '0;
      assign busy_o  = 1'b0;
      assign start_o = 1'b0;
   end

endmodule

// File: rtl/fwc_regs.sv
module fwc_regs #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned SEL_W     = 16,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned NUM_ITEMS = 4,
   parameter bit          DMA_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mmio_req,
   input  logic              mmio_we,
   input  logic [ADDR_W-1:0] mmio_addr,
   input  logic [1:0]        mmio_size,
   input  logic [63:0]       mmio_wdata,
   output logic              mmio_rvalid,
   output logic [63:0]       mmio_rdata,
   input  logic              dma_done,
   output logic              dma_start,
   output logic              dma_busy,
   output logic [63:0]       dma_desc_addr
);
   import fwc_pkg::*;

   localparam int unsigned MAX_LEN = 2 + 3 * (NUM_ITEMS - 1);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("fwc_regs: ADDR_W must cover the 0x14-byte window");
   end
   if (NUM_ITEMS < 2) begin : g_bad_items
      $error("fwc_regs: NUM_ITEMS must include the signature and feature items");
   end
   if (SEL_W < 2 || SEL_W > 16) begin : g_bad_sel
      $error("fwc_regs: SEL_W must be 2..16");
   end
   if (OFF_W < 4 || MAX_LEN >= (1 << OFF_W)) begin : g_bad_off
      $error("fwc_regs: OFF_W too narrow for the item table");
   end

   logic             is_rd, is_wr, data_hit;
   logic             hit_sel, hit_phi, hit_plo;
   logic [3:0]       nbytes;
   logic [SEL_W-1:0] cur_sel;
   logic [OFF_W-1:0] cur_off, item_len_w, avail, adv;
   logic [63:0]      rom_bytes, lane_mask, ptr_val, rd_nxt;
   logic             sel_wr, wr_hi, wr_lo;
   logic [31:0]      hi_d, lo_d;

   assign is_rd    = mmio_req & ~mmio_we;
   assign is_wr    = mmio_req & mmio_we;
   assign data_hit = (32'(mmio_addr) < OFS_SEL);
   assign hit_sel  = (32'(mmio_addr) == OFS_SEL);
   assign hit_phi  = (32'(mmio_addr) == OFS_PHI);
   assign hit_plo  = (32'(mmio_addr) == OFS_PLO);
   assign nbytes   = 4'(1) << mmio_size;

   assign sel_wr = is_wr & hit_sel & (mmio_size == SZ_2);
   assign wr_hi  = is_wr & hit_phi & ((mmio_size == SZ_4) | (mmio_size == SZ_8));
   assign wr_lo  = is_wr & ((hit_plo & (mmio_size == SZ_4)) | (hit_phi & (mmio_size == SZ_8)));
   assign hi_d   = bswap32(mmio_wdata[31:0]);
   assign lo_d   = hit_phi ? bswap32(mmio_wdata[63:32]) : bswap32(mmio_wdata[31:0]);

   fwc_item_rom #(
      .SEL_W(SEL_W), .OFF_W(OFF_W), .NUM_ITEMS(NUM_ITEMS), .DMA_EN(DMA_EN)
   ) i_rom (
      .sel_i   (cur_sel),
      .off_i   (cur_off),
      .bytes_o (rom_bytes),
      .len_o   (item_len_w)
   );

   assign avail = (item_len_w > cur_off) ? (item_len_w - cur_off) : '0;
   assign adv   = (avail < OFF_W'(nbytes)) ? avail : OFF_W'(nbytes);

   fwc_sel_state #(.SEL_W(SEL_W), .OFF_W(OFF_W)) i_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr_i (sel_wr),
      .sel_d_i  (mmio_wdata[SEL_W-1:0]),
      .adv_en_i (is_rd & data_hit),
      .adv_i    (adv),
      .sel_o    (cur_sel),
      .off_o    (cur_off)
   );

   fwc_dma_ptr #(.DMA_EN(DMA_EN)) i_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi_i (wr_hi),
      .wr_lo_i (wr_lo),
      .hi_d_i  (hi_d),
      .lo_d_i  (lo_d),
      .done_i  (dma_done),
      .val_o   (ptr_val),
      .busy_o  (dma_busy),
      .start_o (dma_start)
   );

   assign dma_desc_addr = ptr_val;
   assign lane_mask     = 64'((65'd1 << (8 * nbytes)) - 65'd1);

   always_comb begin
      rd_nxt = '0;
      if (data_hit) begin
         rd_nxt = rom_bytes & lane_mask;
      end else if (hit_phi && mmio_size == SZ_8) begin
         rd_nxt = {bswap32(ptr_val[31:0]), bswap32(ptr_val[63:32])};
      end else if (hit_phi && mmio_size == SZ_4) begin
         rd_nxt = {32'd0, bswap32(ptr_val[63:32])};
      end else if (hit_plo && mmio_size == SZ_4) begin
         rd_nxt = {32'd0, bswap32(ptr_val[31:0])};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mmio_rvalid <= 1'b0;
         mmio_rdata  <= '0;
      end else begin
         mmio_rvalid <= is_rd;
         if (is_rd) mmio_rdata <= rd_nxt;
      end
   end

endmodule

// File: rtl/fwc_chk.sv
module fwc_chk #(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mmio_req,
   input logic              mmio_we,
   input logic [ADDR_W-1:0] mmio_addr,
   input logic [1:0]        mmio_size,
   input logic              mmio_rvalid,
   input logic              dma_done,
   input logic              dma_start,
   input logic              dma_busy,
   input logic [63:0]       dma_desc_addr
);

   p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mmio_req && !mmio_we) |=> mmio_rvalid);

   p_no_rvalid_on_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mmio_req && mmio_we) |=> !mmio_rvalid);

   p_hi_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mmio_req && mmio_we && 32'(mmio_addr) == 32'h0C && mmio_size == 2'd2) |=> !dma_start);

   p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |=> !dma_start);

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> dma_busy);

   p_desc_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_busy && $past(dma_busy) && !$past(dma_done)) |-> $stable(dma_desc_addr));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_busy && dma_done) |=> (!dma_busy && dma_desc_addr == 64'd0));

endmodule

bind fwc_regs fwc_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mmio_req      (mmio_req),
   .mmio_we       (mmio_we),
   .mmio_addr     (mmio_addr),
   .mmio_size     (mmio_size),
   .mmio_rvalid   (mmio_rvalid),
   .dma_done      (dma_done),
   .dma_start     (dma_start),
   .dma_busy      (dma_busy),
   .dma_desc_addr (dma_desc_addr)
);

// File: tb/test_fwc_regs.sv
module test_fwc_regs;
   localparam time PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mmio_req = 1'b0, mmio_we = 1'b0;
   logic [4:0]  mmio_addr = '0;
   logic [1:0]  mmio_size = '0;
   logic [63:0] mmio_wdata = '0;
   logic        mmio_rvalid;
   logic [63:0] mmio_rdata;
   logic        dma_done = 1'b0;
   logic        dma_start, dma_busy;
   logic [63:0] dma_desc_addr;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];

   // model state
   int m_key = 0, m_off = 0;

   always #(PERIOD/2) clk = ~clk;

   fwc_regs i_fwc_regs (
      .clk(clk), .rst_n(rst_n), .mmio_req(mmio_req), .mmio_we(mmio_we),
      .mmio_addr(mmio_addr), .mmio_size(mmio_size), .mmio_wdata(mmio_wdata),
      .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata), .dma_done(dma_done),
      .dma_start(dma_start), .dma_busy(dma_busy), .dma_desc_addr(dma_desc_addr)
   );

   function automatic int mlen(int key);
      if (key <= 1) return 4;
      if (key < 4) return 2 + 3 * key;
      return 0;
   endfunction

   function automatic logic [7:0] mbyte(int key, int i);
      logic [7:0] sig [4] = '{8'h43, 8'h46, 8'h57, 8'h31};
      if (key == 0) return sig[i];
      if (key == 1) return (i == 0) ? 8'h03 : 8'h00;
      return 8'(16 * key + i);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus(logic we, logic [4:0] a, logic [1:0] sz, logic [63:0] wd);
      @(negedge clk);
      mmio_req = 1'b1; mmio_we = we; mmio_addr = a; mmio_size = sz; mmio_wdata = wd;
      @(negedge clk);
      mmio_req = 1'b0; mmio_we = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, logic [1:0] sz, logic [63:0] exp, string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus(1'b0, a, sz, '0);
   endtask

   task automatic select(int key);
      bus(1'b1, 5'h08, 2'd1, 64'(key));
      m_key = key; m_off = 0;
   endtask

   // data read with expected value from the model
   task automatic drd(int n, string tag);
      logic [63:0] e = '0;
      for (int k = 0; k < n; k++) begin
         if (m_off < mlen(m_key)) begin
            e[8*k +: 8] = mbyte(m_key, m_off);
            m_off++;
         end
      end
      rd(5'h00, 2'($clog2(n)), e, tag);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mmio_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12: unexpected read data actual %h expected none", mmio_rdata);
         end else begin
            check(tag_q.pop_front(), mmio_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy", 64'(dma_busy), 64'd0);
      check("R1 start", 64'(dma_start), 64'd0);
      check("R1 desc", dma_desc_addr, 64'd0);
      rd(5'h0C, 2'd3, 64'd0, "R1 ptr read");
      drd(1, "R1 key0 byte0");
      drd(2, "R2 key0 bytes1-2");

      // key 3: 11 bytes
      select(3);
      drd(4, "R2 key3 4-byte");
      drd(2, "R2 key3 2-byte");
      drd(1, "R2 key3 1-byte");
      drd(8, "R4 key3 crossing end");
      drd(4, "R4 key3 after end");

      select(2);
      drd(8, "R3 key2 full");
      select(2);
      drd(1, "R3 reselect resets cursor");

      select(1);
      drd(4, "R5 feature bitmap");
      select(7);
      drd(8, "R4 unknown key empty");

      // ignored accesses
      select(2);
      drd(2, "R12 pre");
      bus(1'b1, 5'h00, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      drd(1, "R12 data write ignored");
      bus(1'b1, 5'h0A, 2'd1, 64'd3);
      drd(1, "R12 offset 0xA write ignored");
      rd(5'h14, 2'd2, 64'd0, "R12 unmapped read zero");
      bus(1'b1, 5'h14, 2'd2, 64'hAAAA_AAAA);
      check("R12 unmapped write no start", 64'(dma_start), 64'd0);

      // two-write pointer load
      bus(1'b1, 5'h0C, 2'd2, 64'h1122_3344);
      check("R6 hi write no start", 64'(dma_start), 64'd0);
      check("R6 hi stored big-endian", dma_desc_addr, 64'h4433_2211_0000_0000);
      rd(5'h0C, 2'd2, 64'h1122_3344, "R11 hi half readback");
      bus(1'b1, 5'h10, 2'd2, 64'h5566_7788);
      check("R7 start pulse", 64'(dma_start), 64'd1);
      check("R7 desc value", dma_desc_addr, 64'h4433_2211_8877_6655);
      check("R9 busy with start", 64'(dma_busy), 64'd1);
      @(negedge clk);
      check("R7 start one cycle", 64'(dma_start), 64'd0);
      bus(1'b1, 5'h0C, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R9 write while busy ignored", dma_desc_addr, 64'h4433_2211_8877_6655);
      check("R9 no restart while busy", 64'(dma_start), 64'd0);
      rd(5'h0C, 2'd3, 64'h5566_7788_1122_3344, "R11 8-byte readback");
      rd(5'h10, 2'd2, 64'h5566_7788, "R11 lo half readback");
      check("R9 still busy", 64'(dma_busy), 64'd1);
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;
      check("R10 busy cleared", 64'(dma_busy), 64'd0);
      check("R10 desc cleared", dma_desc_addr, 64'd0);
      rd(5'h0C, 2'd3, 64'd0, "R10 ptr reads zero");

      // single 64-bit write
      bus(1'b1, 5'h0C, 2'd3, 64'h0807_0605_0403_0201);
      check("R8 start", 64'(dma_start), 64'd1);
      check("R8 desc", dma_desc_addr, 64'h0102_0304_0506_0708);
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;

      // 32-bit pointer in one write
      bus(1'b1, 5'h10, 2'd2, 64'hDDCC_BBAA);
      check("R7 single low write start", 64'(dma_start), 64'd1);
      check("R7 single low write desc", dma_desc_addr, 64'h0000_0000_AABB_CCDD);
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;
      check("R10 clear again", dma_desc_addr, 64'd0);

      repeat (3) @(negedge clk);
      check("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
      summary();
   end

endmodule